// File: doc/BRIEF.md
# Accumulator, Link and Operate Microinstruction Unit

This block holds the 12-bit accumulator and the 1-bit link of a small 12-bit CPU, together with the incrementer and rotator that carry out operate-class instructions (opcode 7). An external sequencer steps each instruction through three execution states, named F1, F2 and E0, and holds the instruction word steady while it does so. In each state the unit applies only the micro-operations assigned to that state. An operate instruction therefore always takes the same states, however many micro-operations it combines.

Group 1 words (IR[8]=0) clear, complement, increment and rotate. The increment feeds the rotator within the E0 cycle. A double rotate is done in a single pass. Group 2 words (IR[8]=1, IR[0]=0) test the accumulator and link in F1 and raise a skip request. In F2 they may clear the accumulator or request a halt. The switch-register OR bit of group 2 does nothing. For add and logical-and instructions, an ALU outside the block writes its result into the accumulator and link through a direct load port. The block also drives the sign, zero-accumulator and zero-link flags continuously.

Top module: `acc_link_unit`

## Requirements
- R1: After the asynchronous active-low reset, AC reads 0 and the link reads 0.
- R2: When alu_load_i is high at a rising edge, AC takes alu_ac_i and the link takes alu_link_i at that edge, whatever the state and instruction inputs.
- R3: A group 1 word in state F1 clears AC when bit 7 (octal 0200) is set and clears the link when bit 6 (0100) is set.
- R4: A group 1 word in state F2 inverts AC when bit 5 (0040) is set and inverts the link when bit 4 (0020) is set.
- R5: A group 1 word in state E0 with bit 0 (0001) set adds one to the 13-bit value {link, AC}, so a carry out of AC bit 11 inverts the link. The incremented value feeds the rotator in the same cycle.
- R6: In E0, a group 1 word with bit 3 (0010) set rotates {link, AC} right, and one with bit 2 (0004) set rotates it left, by one place. Bit 1 (0002) makes the rotation two places in one cycle. With both bits 3 and 2 set, or with bit 1 set alone, there is no rotation.
- R7: A group 2 word in F1 raises skip_o when any selected test holds: bit 6 (0100) tests AC bit 11 set, bit 5 (0040) tests AC equal to zero, and bit 4 (0020) tests the link set. With bit 3 (0010) set, skip_o is raised instead when all selected tests fail. skip_o is low in every other state.
- R8: A group 2 word in F2 clears AC when bit 7 (0200) is set and raises halt_o when bit 1 (0002) is set. Bit 2 (0004) changes nothing. halt_o is low in every other state.
- R9: neg_ac_o equals AC bit 11, zero_ac_o is high exactly when AC is 0, and zero_l_o is high exactly when the link is 0.
- R10: State F0, a word whose bits 11..9 are not all ones, and a word with both bit 8 and bit 0 set each leave AC and the link unchanged and keep skip_o and halt_o low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| state_i | input | 2 | Execution state: 0 F0, 1 F1, 2 F2, 3 E0 |
| ir_i | input | 12 | Instruction word, held steady during F1, F2 and E0 |
| alu_load_i | input | 1 | Load AC and link from the ALU |
| alu_ac_i | input | 12 | ALU result for AC |
| alu_link_i | input | 1 | ALU result for the link |
| ac_o | output | 12 | Accumulator |
| link_o | output | 1 | Link |
| neg_ac_o | output | 1 | AC bit 11 |
| zero_ac_o | output | 1 | AC equals zero |
| zero_l_o | output | 1 | Link equals zero |
| skip_o | output | 1 | Skip request from a group 2 word in F1 |
| halt_o | output | 1 | Halt request from a group 2 word in F2 |

## Verification
The assertions rely on the sequencer holding ir_i constant through F1, F2 and E0. They also rely on alu_load_i being raised only when no operate micro-operation is due, apart from the one deliberate priority case. The assertions on clearing, complementing and rotating are therefore conditioned on alu_load_i being low. The stimulus respects these assumptions: it loads the starting AC and link only in F0, then drives each word through F1, F2, E0 and back to F0 with the word held steady. The one exception is a single case that raises the load together with an F1 group 1 clear, to show that the load takes priority.

// File: rtl/acc_pkg.sv
`timescale 1ns/1ps
package acc_pkg;
  localparam int unsigned WORD_W = 12;

  typedef enum logic [1:0] {
    ST_F0 = 2'd0,
    ST_F1 = 2'd1,
    ST_F2 = 2'd2,
    ST_E0 = 2'd3
  } op_state_e;
endpackage

// File: rtl/acc_incr_rot.sv
`timescale 1ns/1ps
// E0 datapath: 13-bit increment followed by 0/1/2-place rotation in one cycle
module acc_incr_rot #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] ac_i,
  input  logic         link_i,
  input  logic         inc_i,
  input  logic         rar_i,
  input  logic         ral_i,
  input  logic         twice_i,
  output logic [W-1:0] ac_o,
  output logic         link_o
);
  localparam int unsigned VW = W + 1;

  logic [VW-1:0] v_in, v_inc, v_rot;

  assign v_in  = {link_i, ac_i};
  assign v_inc = v_in + VW'(inc_i);

  always_comb begin
    unique case ({rar_i, ral_i, twice_i})
      3'b100:  v_rot = {v_inc[0], v_inc[VW-1:1]};
      3'b101:  v_rot = {v_inc[1:0], v_inc[VW-1:2]};
      3'b010:  v_rot = {v_inc[VW-2:0], v_inc[VW-1]};
      3'b011:  v_rot = {v_inc[VW-3:0], v_inc[VW-1:VW-2]};
      default: v_rot = v_inc;
    endcase
  end

  assign ac_o   = v_rot[W-1:0];
  assign link_o = v_rot[VW-1];
endmodule

// File: rtl/acc_skip_eval.sv
`timescale 1ns/1ps
module acc_skip_eval #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] ac_i,
  input  logic         link_i,
  input  logic         sma_i,
  input  logic         sza_i,
  input  logic         snl_i,
  input  logic         rev_i,
  output logic         skip_o
);
  logic any_hit;

  assign any_hit = (sma_i & ac_i[W-1]) | (sza_i & (ac_i == '0)) | (snl_i & link_i);
  // reversed sense: skip when every selected test fails
  assign skip_o  = rev_i ? ~any_hit : any_hit;
endmodule

// File: rtl/acc_link_unit.sv
`timescale 1ns/1ps
module acc_link_unit
  import acc_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [1:0]   state_i,
  input  logic [W-1:0] ir_i,
  input  logic         alu_load_i,
  input  logic [W-1:0] alu_ac_i,
  input  logic         alu_link_i,
  output logic [W-1:0] ac_o,
  output logic         link_o,
  output logic         neg_ac_o,
  output logic         zero_ac_o,
  output logic         zero_l_o,
  output logic         skip_o,
  output logic         halt_o
);
  op_state_e   st;
  logic [W-1:0] ac_q, ac_d, e0_ac;
  logic         l_q, l_d, e0_l;
  logic         is_opr, grp1, grp2, skip_raw;

  assign st     = op_state_e'(state_i);
  assign is_opr = (ir_i[W-1 -: 3] == 3'b111);
  assign grp1   = is_opr & ~ir_i[8];
  assign grp2   = is_opr &  ir_i[8] & ~ir_i[0];

  acc_incr_rot #(.W(W)) u_incr_rot (
    .ac_i    (ac_q),
    .link_i  (l_q),
    .inc_i   (ir_i[0]),
    .rar_i   (ir_i[3]),
    .ral_i   (ir_i[2]),
    .twice_i (ir_i[1]),
    .ac_o    (e0_ac),
    .link_o  (e0_l)
  );

  acc_skip_eval #(.W(W)) u_skip_eval (
    .ac_i   (ac_q),
    .link_i (l_q),
    .sma_i  (ir_i[6]),
    .sza_i  (ir_i[5]),
    .snl_i  (ir_i[4]),
    .rev_i  (ir_i[3]),
    .skip_o (skip_raw)
  );

  always_comb begin
    ac_d = ac_q;
    l_d  = l_q;
    if (alu_load_i) begin
      ac_d = alu_ac_i;
      l_d  = alu_link_i;
    end else begin
      unique case (st)
        ST_F1: if (grp1) begin
          if (ir_i[7]) ac_d = '0;
          if (ir_i[6]) l_d  = 1'b0;
        end
        ST_F2: begin
          if (grp1) begin
            if (ir_i[5]) ac_d = ~ac_q;
            if (ir_i[4]) l_d  = ~l_q;
          end
          if (grp2 && ir_i[7]) ac_d = '0;
        end
        ST_E0: if (grp1) begin
          ac_d = e0_ac;
          l_d  = e0_l;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_q <= '0;
      l_q  <= 1'b0;
    end else begin
      ac_q <= ac_d;
      l_q  <= l_d;
    end
  end

  assign ac_o      = ac_q;
  assign link_o    = l_q;
  assign neg_ac_o  = ac_q[W-1];
  assign zero_ac_o = (ac_q == '0);
  assign zero_l_o  = ~l_q;
  assign skip_o    = grp2 & (st == ST_F1) & skip_raw;
  assign halt_o    = grp2 & (st == ST_F2) & ir_i[1];

  assert_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_load_i |=> (ac_o == $past(alu_ac_i)) && (link_o == $past(alu_link_i)));

  assert_clear_f1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_load_i && st == ST_F1 && grp1 && ir_i[7] && ir_i[6]) |=> (ac_o == '0) && !link_o);

  assert_cma_f2_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_load_i && st == ST_F2 && grp1 && ir_i[5]) |=> ac_o == ~$past(ac_o));

  assert_rot_keeps_ones_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_load_i && st == ST_E0 && grp1 && !ir_i[0] && (ir_i[3] ^ ir_i[2]))
    |=> $countones({link_o, ac_o}) == $countones($past({link_o, ac_o})));

  assert_skip_window_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_o |-> (st == ST_F1));

  assert_halt_window_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> (st == ST_F2));

  assert_osr_inert_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_load_i && st == ST_F2 && grp2 && ir_i[2] && !ir_i[7]) |=> $stable(ac_o) && $stable(link_o));

  assert_idle_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!alu_load_i && (st == ST_F0 || !is_opr)) |=> $stable(ac_o) && $stable(link_o));
endmodule

// File: tb/acc_link_unit_tb_top.sv
`timescale 1ns/1ps
module acc_link_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [1:0]  state_i = 2'd0;
  logic [11:0] ir_i = '0;
  logic        alu_load_i = 1'b0;
  logic [11:0] alu_ac_i = '0;
  logic        alu_link_i = 1'b0;
  logic [11:0] ac_o;
  logic        link_o, neg_ac_o, zero_ac_o, zero_l_o, skip_o, halt_o;

  always #2.5 clk = ~clk;

  acc_link_unit dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .state_i(state_i), .ir_i(ir_i),
    .alu_load_i(alu_load_i), .alu_ac_i(alu_ac_i), .alu_link_i(alu_link_i),
    .ac_o(ac_o), .link_o(link_o), .neg_ac_o(neg_ac_o), .zero_ac_o(zero_ac_o),
    .zero_l_o(zero_l_o), .skip_o(skip_o), .halt_o(halt_o)
  );

  typedef struct {
    logic [11:0] ir;
    logic [11:0] ac;
    logic        l;
    logic        sk;
    logic        hl;
    logic        sk_obs;
    logic        hl_obs;
    string       tag;
  } item_t;

  item_t sb_q[$];
  event  item_ev;
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  task automatic chk(input string tag, input logic [11:0] ir, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s ir=%o actual=%o expected=%o", tag, ir, act, exp);
    end
  endtask

  // Reference model written from the requirements
  task automatic model(input logic [11:0] ir, inout logic [11:0] ac, inout logic l,
                       output logic sk, output logic hl);
    logic hit, t;
    sk = 1'b0; hl = 1'b0;
    if (ir[11:9] != 3'o7) return;
    if (!ir[8]) begin
      if (ir[7]) ac = '0;
      if (ir[6]) l = 1'b0;
      if (ir[5]) ac = ~ac;
      if (ir[4]) l = ~l;
      if (ir[0]) begin
        ac = ac + 12'd1;
        if (ac == 12'd0) l = ~l;
      end
      if (ir[3] ^ ir[2]) begin
        for (int i = 0; i < (ir[1] ? 2 : 1); i++) begin
          if (ir[3]) begin t = ac[0]; ac = {l, ac[11:1]}; l = t; end
          else begin t = ac[11]; ac = {ac[10:0], l}; l = t; end
        end
      end
    end else if (!ir[0]) begin
      hit = (ir[6] && ac[11]) || (ir[5] && ac == 12'd0) || (ir[4] && l);
      sk = ir[3] ? !hit : hit;
      hl = ir[1];
      if (ir[7]) ac = '0;
    end
  endtask

  task automatic load(input logic [11:0] a, input logic l);
    alu_load_i = 1'b1; alu_ac_i = a; alu_link_i = l;
    @(negedge clk);
    alu_load_i = 1'b0;
  endtask

  // Driver: computes expectation, walks F1/F2/E0, pushes to scoreboard
  task automatic run_op(input logic [11:0] ir, input logic [11:0] a0, input logic l0, input string tag);
    item_t it;
    logic [11:0] a; logic l; logic sk, hl;
    load(a0, l0);
    a = a0; l = l0;
    model(ir, a, l, sk, hl);
    it.ir = ir; it.ac = a; it.l = l; it.sk = sk; it.hl = hl; it.tag = tag;
    ir_i = ir; state_i = 2'd1;
    #1 it.sk_obs = skip_o;
    chk({tag, " halt low in F1"}, ir, halt_o, 0);
    @(negedge clk); state_i = 2'd2;
    #1 it.hl_obs = halt_o;
    chk({tag, " skip low in F2"}, ir, skip_o, 0);
    @(negedge clk); state_i = 2'd3;
    #1 chk({tag, " skip/halt low in E0"}, ir, {skip_o, halt_o}, 0);
    @(negedge clk); state_i = 2'd0;
    sb_q.push_back(it);
    -> item_ev;
    @(negedge clk);
  endtask

  // Monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      @(item_ev);
      #1;
      while (sb_q.size() > 0) begin
        item_t e;
        e = sb_q.pop_front();
        chk({e.tag, " ac"}, e.ir, ac_o, e.ac);
        chk({e.tag, " link"}, e.ir, link_o, e.l);
        chk({e.tag, " skip"}, e.ir, e.sk_obs, e.sk);
        chk({e.tag, " halt"}, e.ir, e.hl_obs, e.hl);
        chk("R9 neg_ac", e.ir, neg_ac_o, e.ac[11]);
        chk("R9 zero_ac", e.ir, zero_ac_o, e.ac == 12'd0);
        chk("R9 zero_l", e.ir, zero_l_o, !e.l);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7319));
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ac", '0, ac_o, 0);
    chk("R1 link", '0, link_o, 0);
    chk("R9 reset flags", '0, {neg_ac_o, zero_ac_o, zero_l_o}, 3'b011);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: load wins over a simultaneous F1 clear
    ir_i = 12'o7300; state_i = 2'd1;
    alu_load_i = 1'b1; alu_ac_i = 12'o5252; alu_link_i = 1'b1;
    @(negedge clk);
    alu_load_i = 1'b0; state_i = 2'd0;
    chk("R2 ac", ir_i, ac_o, 12'o5252);
    chk("R2 link", ir_i, link_o, 1);

    // R5 corner: increment carry wraps AC and flips the link
    run_op(12'o7001, 12'o7777, 1'b0, "R5 carry");
    run_op(12'o7001, 12'o7777, 1'b1, "R5 carry");
    run_op(12'o7011, 12'o7777, 1'b0, "R5 R6 inc-then-rar");
    run_op(12'o7007, 12'o3777, 1'b1, "R5 R6 inc-then-rtl");

    // R3 R4 R5 R6: every group 1 word, random and all-ones start
    for (int w = 0; w < 256; w++) begin
      run_op(12'o7000 | 12'(w), 12'($urandom), 1'($urandom), "R3 R4 R5 R6");
      run_op(12'o7000 | 12'(w), 12'o7777, 1'($urandom), "R3 R4 R5 R6");
    end

    // R7 R8: every group 2 word, random, zero and negative starts
    for (int w = 0; w < 128; w++) begin
      run_op(12'o7400 | 12'(w << 1), 12'($urandom), 1'($urandom), "R7 R8");
      run_op(12'o7400 | 12'(w << 1), 12'o0000, 1'($urandom), "R7 R8");
      run_op(12'o7400 | 12'(w << 1), 12'o4000, 1'($urandom), "R7 R8");
    end

    // R10: non-operate and group 3 words change nothing
    run_op(12'o1377, 12'o1234, 1'b1, "R10 non-operate");
    run_op(12'o5201, 12'o0000, 1'b0, "R10 non-operate");
    run_op(12'o7401, 12'o4321, 1'b1, "R10 group3");
    run_op(12'o7777, 12'o0000, 1'b1, "R10 group3");

    // R10: F0 holds with an operate word present
    ir_i = 12'o7301;
    repeat (3) @(negedge clk);
    #1 chk("R10 F0 hold ac", ir_i, ac_o, 12'o0000);
    chk("R10 F0 hold link", ir_i, link_o, 1);
    chk("R10 F0 skip/halt", ir_i, {skip_o, halt_o}, 0);

    repeat (2) @(negedge clk);
    chk("scoreboard drained", '0, sb_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule